// File: doc/BRIEF.md
# Quad Rail Undervoltage/Overvoltage Supervisor Output Controller

This block turns the threshold results of four monitored supply rails into two active-low fault outputs, one for undervoltage (UV) and one for overvoltage (OV). Each rail supplies two synchronous comparator flags. The high-tap flag is set when the upper divider tap is below threshold. The low-tap flag is set when the lower divider tap is above threshold. Rails 1 and 2 always monitor positive supplies. A polarity select decides whether rails 3 and 4 monitor positive or negative supplies. On a negative rail, the two flags swap the fault type they report.

Both outputs stay asserted for a programmable number of clock cycles after the last fault of their type. An input can bypass this timeout. The OV output can also latch, and a clear input releases the latch. While that clear input is held high, OV uses the same timing as UV. An output disable masks both outputs. An undervoltage-lockout input overrides the disable and forces both outputs asserted.

Top module: `rail_fault_supervisor`

## Requirements
- R1: Rails 1 and 2 (bits 0 and 1) are always positive: a set `hi_below` bit raises a UV fault and a set `lo_above` bit raises an OV fault.
- R2: `pol_sel` encodes the polarity of rails 3 and 4 (bits 2 and 3). 2'b01 makes both positive. 2'b10 makes both negative. 2'b00 and 2'b11 make rail 3 positive and rail 4 negative.
- R3: On a negative rail, a set `hi_below` bit raises an OV fault and a set `lo_above` bit raises a UV fault.
- R4: `uv_n` and `ov_n` are active low. A fault of either type on any rail, sampled at a rising clock edge, drives the matching output low after that edge.
- R5: Let e be the last edge at which a UV fault was sampled. UV deasserts at edge e+TIMEOUT. A new fault during the countdown restarts it.
- R6: While `latch_clr` is low, a sampled OV fault latches OV. OV stays asserted, even after the fault is gone, until `latch_clr` goes high.
- R7: While `latch_clr` is high, the latch is cleared and OV follows the same delayed release as UV (edge e+TIMEOUT after its last fault).
- R8: While `out_dis` is high and `lockout` is low, both outputs are high, whatever the faults are.
- R9: While `lockout` is high, both outputs are low at once, and both timeouts are held at their start.
- R10: While `tmr_bypass` is high, an asserted output releases at the first edge that samples no fault of its type.
- R11: While `rst_n` is low, both outputs are low (unless `out_dis` is high) and the OV latch is cleared. After reset, both outputs release TIMEOUT edges later if no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 2 | Polarity code for rails 3 and 4 |
| hi_below | input | 4 | Per rail: high tap below threshold |
| lo_above | input | 4 | Per rail: low tap above threshold |
| latch_clr | input | 1 | High clears the OV latch and selects delayed (non-latching) OV |
| out_dis | input | 1 | Masks both outputs unless in lockout |
| lockout | input | 1 | Undervoltage lockout, forces both outputs asserted |
| tmr_bypass | input | 1 | Removes the release timeout |
| uv_n | output | 1 | Undervoltage output, active low |
| ov_n | output | 1 | Overvoltage output, active low |

## Verification
Lockout and output disable can be active in the same cycle, and lockout must win. The bench raises both together while a latched OV is pending, and while UV faults come and go. A second overlap occurs when a new fault arrives in the cycle the countdown would otherwise expire. The bench places a fault TIMEOUT-1 edges after the previous one and expects the release to move out by a full period. A behavioural model with integer cycle counts predicts both outputs on every clock.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int TIMEOUT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pol_sel,
  input  logic [3:0] hi_below,
  input  logic [3:0] lo_above,
  input  logic       latch_clr,
  input  logic       out_dis,
  input  logic       lockout,
  input  logic       tmr_bypass,
  output logic       uv_n,
  output logic       ov_n
);
  localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [3:0] neg;
  logic uv_hit, ov_hit;
  logic uv_hold, ov_hold, ov_lat;
  logic [CW-1:0] uv_cnt, ov_cnt;

  assign neg    = {pol_sel != 2'b01, pol_sel == 2'b10, 2'b00};
  assign uv_hit = |((hi_below & ~neg) | (lo_above & neg));
  assign ov_hit = |((lo_above & ~neg) | (hi_below & neg));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      uv_hold <= 1'b1;
      uv_cnt  <= '0;
    end else if (lockout || uv_hit) begin
      uv_hold <= 1'b1;
      uv_cnt  <= '0;
    end else if (uv_hold) begin
      if (tmr_bypass || uv_cnt == LAST) begin
        uv_hold <= 1'b0;
        uv_cnt  <= '0;
      end else begin
        uv_cnt <= uv_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ov_lat <= 1'b0;
    else        ov_lat <= !latch_clr && (ov_lat || ov_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ov_hold <= 1'b1;
      ov_cnt  <= '0;
    end else if (lockout || ov_hit || (ov_lat && !latch_clr)) begin
      ov_hold <= 1'b1;
      ov_cnt  <= '0;
    end else if (ov_hold) begin
      if (tmr_bypass || ov_cnt == LAST) begin
        ov_hold <= 1'b0;
        ov_cnt  <= '0;
      end else begin
        ov_cnt <= ov_cnt + 1'b1;
      end
    end

  assign uv_n = ~(lockout | (uv_hold & ~out_dis));
  assign ov_n = ~(lockout | (ov_hold & ~out_dis));
endmodule

// File: rtl/rail_fault_supervisor_chk.sv
module rail_fault_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] hi_below,
  input logic [3:0] lo_above,
  input logic       latch_clr,
  input logic       out_dis,
  input logic       lockout,
  input logic       uv_n,
  input logic       ov_n
);
  a_r9_lockout_forces: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (!uv_n && !ov_n));

  a_r8_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dis && !lockout) |-> (uv_n && ov_n));

  a_r1_uv_follows_rail1: assert property (@(posedge clk) disable iff (!rst_n)
    hi_below[0] |=> (!uv_n || out_dis));

  a_r6_ov_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_above[0] && !latch_clr) |=> (latch_clr || out_dis || !ov_n));

  a_r5_no_release_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_n) |-> (!$past(hi_below[0]) || out_dis));
endmodule

bind rail_fault_supervisor rail_fault_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
  .latch_clr(latch_clr), .out_dis(out_dis), .lockout(lockout),
  .uv_n(uv_n), .ov_n(ov_n)
);

// File: tb/rail_fault_supervisor_bench.sv
module rail_fault_supervisor_bench;
  localparam int T = 6;
  localparam time HP = 2.5ns;

  logic clk = 0, rst_n = 0;
  logic [1:0] pol_sel = 2'b01;
  logic [3:0] hi_below = 0, lo_above = 0;
  logic latch_clr = 1, out_dis = 0, lockout = 0, tmr_bypass = 0;
  logic uv_n, ov_n;

  int n_chk = 0, n_fail = 0;
  string req = "R11";
  bit done = 0;

  rail_fault_supervisor #(.TIMEOUT(T)) u_rail_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .hi_below(hi_below),
    .lo_above(lo_above), .latch_clr(latch_clr), .out_dis(out_dis),
    .lockout(lockout), .tmr_bypass(tmr_bypass), .uv_n(uv_n), .ov_n(ov_n));

  always #HP clk = ~clk;

  bit uvh = 1, ovh = 1, lat = 0;
  int uvs = 0, ovs = 0;

  task automatic faults(output bit uf, output bit of);
    bit n3, n4;
    case (pol_sel)
      2'b01:   begin n3 = 0; n4 = 0; end
      2'b10:   begin n3 = 1; n4 = 1; end
      default: begin n3 = 0; n4 = 1; end
    endcase
    uf = 0; of = 0;
    for (int r = 0; r < 4; r++) begin
      bit ng = (r == 2) ? n3 : (r == 3) ? n4 : 1'b0;
      if (hi_below[r]) begin if (ng) of = 1; else uf = 1; end
      if (lo_above[r]) begin if (ng) uf = 1; else of = 1; end
    end
  endtask

  always @(posedge clk) begin
    bit uf, of, nl;
    if (!rst_n) begin
      uvh = 1; ovh = 1; lat = 0; uvs = 0; ovs = 0;
    end else begin
      faults(uf, of);
      if (lockout || uf) begin uvh = 1; uvs = 0; end
      else if (uvh) begin uvs++; if (tmr_bypass || uvs >= T) uvh = 0; end
      nl = !latch_clr && (lat || of);
      if (lockout || of || (lat && !latch_clr)) begin ovh = 1; ovs = 0; end
      else if (ovh) begin ovs++; if (tmr_bypass || ovs >= T) ovh = 0; end
      lat = nl;
    end
  end

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(req, uv_n, !(lockout | (((!rst_n) | uvh) & !out_dis)), "uv_n");
    check(req, ov_n, !(lockout | (((!rst_n) | ovh) & !out_dis)), "ov_n");
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_hi(int r, int len);
    hi_below[r] = 1; step(len); hi_below[r] = 0;
  endtask

  task automatic pulse_lo(int r, int len);
    lo_above[r] = 1; step(len); lo_above[r] = 0;
  endtask

  initial begin
    #(2 * HP * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    req = "R11";
    @(negedge clk);
    check("R11", uv_n, 1'b0, "uv_n in reset");
    check("R11", ov_n, 1'b0, "ov_n in reset");
    step(0);
    rst_n = 1;
    step(T + 2);
    check("R11", uv_n, 1'b1, "uv_n released after reset");
    req = "R1";
    pulse_hi(0, 2); step(T + 2);
    pulse_lo(1, 1); step(T + 2);
    for (int s = 0; s < 4; s++) begin
      pol_sel = s[1:0];
      req = "R2";
      pulse_hi(2, 1); step(T + 2);
      pulse_lo(2, 1); step(T + 2);
      req = "R3";
      pulse_hi(3, 1); step(T + 2);
      pulse_lo(3, 1); step(T + 2);
    end
    pol_sel = 2'b10;
    req = "R3";
    hi_below[2] = 1;
    step(1);
    @(negedge clk);
    check("R3", ov_n, 1'b0, "negative rail high tap gives OV");
    check("R3", uv_n, 1'b1, "negative rail high tap no UV");
    step(0);
    hi_below[2] = 0; step(T + 2);
    pol_sel = 2'b01;
    req = "R4";
    hi_below = 4'b1010; lo_above = 4'b0101; step(2);
    hi_below = 0; lo_above = 0; step(T + 2);
    req = "R5";
    pulse_hi(1, 1); step(T - 2); pulse_hi(1, 1); step(T - 1);
    @(negedge clk);
    check("R5", uv_n, 1'b0, "restarted countdown still asserted");
    step(3);
    check("R5", uv_n, 1'b1, "released after full period");
    req = "R6";
    latch_clr = 0;
    pulse_lo(0, 1); step(3 * T);
    check("R6", ov_n, 1'b0, "OV held by latch");
    req = "R8";
    out_dis = 1; step(2);
    pulse_hi(0, 2); step(2);
    req = "R9";
    lockout = 1; step(3);
    lockout = 0; out_dis = 0;
    req = "R7";
    latch_clr = 1; step(T - 1);
    check("R7", ov_n, 1'b0, "OV still timing after clear");
    step(3);
    check("R7", ov_n, 1'b1, "OV released after clear and timeout");
    pulse_lo(0, 1); step(T + 2);
    req = "R9";
    lockout = 1; step(2); lockout = 0; step(T + 2);
    req = "R10";
    tmr_bypass = 1;
    pulse_hi(0, 2); pulse_lo(1, 1);
    @(negedge clk);
    check("R10", uv_n, 1'b1, "UV released at once with bypass");
    step(3);
    tmr_bypass = 0;
    req = "R11";
    latch_clr = 0; pulse_lo(0, 1); step(2);
    rst_n = 0; step(2); rst_n = 1; latch_clr = 0; step(T + 2);
    check("R11", ov_n, 1'b1, "latch cleared by reset");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule